// File: doc/BRIEF.md
# Vector Compare-to-Predicate Unit

This block executes compare operations that reuse the encodings of conditional branches and of single-precision floating-point compares. It does not redirect the program counter. It compares pairs of vector elements and builds a bitmask. Each element pair yields one bit, and the finished mask is written into a predicate register chosen by the destination field of the instruction.

The block sequences one element per clock. It reads operands through two register read ports that it shares between the integer file and the floating-point file, and it selects the data of the file that the decoded operation calls for. An operand whose configured length is one or less is a scalar and is reused for every element. A longer operand steps through consecutive registers.

When the last element is done, the whole mask is presented on a write port for one cycle, and a done strobe follows. An operation that is disabled or badly encoded raises an error strobe and writes nothing.

Top module: `vcmp_pred_unit`

## Requirements
- R1: After reset, `pw_en`, `done` and `illegal` are all low.
- R2: Opcode 1100011 selects an integer compare from instr[14:12]: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Bits 31..25, which a branch would use for its offset, have no effect.
- R3: Opcode 1010011 with instr[31:27]=10100 and instr[26:25] in {00,01,11} selects a single-precision compare: 000 less-or-equal, 001 less-than, 010 equal, 011 not-equal. Any NaN operand makes the first three 0 and not-equal 1. +0 and -0 are equal.
- R4: The mask goes to the predicate register indexed by instr[11:7]. `pw_fp` is 1 for a floating-point compare and 0 for an integer compare. The same selector picks which register file supplies the operands.
- R5: An operand with a configured length of 0 or 1 reads register rs (instr[19:15] or instr[24:20]) for every element. Otherwise element i reads register rs+i, modulo 32.
- R6: The element count is the larger of the two operand lengths, at least 1 and at most PRED_W. Mask bits at or above that count are written as 0.
- R7: When a start is accepted at clock edge E0, `pw_en` is high for exactly the one cycle after edge E(n), where n is the element count. `done` is high for the one cycle that follows.
- R8: If the enable flag for the selected kind is low, or the opcode or function code is not listed in R2/R3, then `illegal` is high for the one cycle after the start edge, and neither `pw_en` nor `done` rises.
- R9: A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the operation in `instr` |
| instr | input | 32 | Instruction word |
| int_pred_en | input | 1 | Predication enabled for integer compares |
| fp_pred_en | input | 1 | Predication enabled for FP compares |
| vl_a | input | VL_W | Configured length of first source register |
| vl_b | input | VL_W | Configured length of second source register |
| rd_addr_a | output | 5 | Read address, first operand |
| rd_addr_b | output | 5 | Read address, second operand |
| int_a | input | XLEN | Integer file data at `rd_addr_a` |
| int_b | input | XLEN | Integer file data at `rd_addr_b` |
| fp_a | input | 32 | FP file data at `rd_addr_a` |
| fp_b | input | 32 | FP file data at `rd_addr_b` |
| pw_en | output | 1 | Predicate register write strobe |
| pw_fp | output | 1 | Predicate table select (1 = FP) |
| pw_idx | output | 5 | Predicate register index |
| pw_mask | output | PRED_W | Mask written |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Operation rejected |

## Verification
The bench builds the block with its defaults: PRED_W=16, VL_W=8, XLEN=32 and the floating-point variant enabled. Because VL_W is 8, lengths up to 20 can be driven. That covers the cap at 16 and element addresses that wrap past register 31. Enabling the floating-point variant exposes NaN, signed zero and infinity operands alongside the integer codes.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

   typedef enum logic [2:0] {
      K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU, K_FLE, K_FLT
   } cmp_kind_e;

   typedef enum logic [2:0] {
      S_IDLE, S_RUN, S_WRITE, S_FIN, S_ERR
   } seq_state_e;

   typedef struct packed {
      logic      is_fp;
      cmp_kind_e kind;
      logic [4:0] src_a;
      logic [4:0] src_b;
      logic [4:0] dst;
   } cmp_op_t;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_FP     = 7'b1010011;
   localparam logic [4:0] FP_CMP_F5  = 5'b10100;

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
   import vcmp_pkg::*;
#(
   parameter bit FP_EN = 1'b1
) (
   input  logic [31:0] instr,
   input  logic        int_en,
   input  logic        fp_en,
   output cmp_op_t     op,
   output logic        legal
);
   logic [2:0] f3;
   logic       fp_form;

   assign f3      = instr[14:12];
   assign fp_form = FP_EN && (instr[6:0] == OPC_FP) && (instr[31:27] == FP_CMP_F5)
                    && (instr[26:25] != 2'b10);

   always_comb begin
      op.src_a = instr[19:15];
      op.src_b = instr[24:20];
      op.dst   = instr[11:7];
      op.is_fp = 1'b0;
      op.kind  = K_EQ;
      legal    = 1'b0;
      if (instr[6:0] == OPC_BRANCH) begin
         legal = int_en;
         unique case (f3)
            3'b000:  op.kind = K_EQ;
            3'b001:  op.kind = K_NE;
            3'b100:  op.kind = K_LT;
            3'b101:  op.kind = K_GE;
            3'b110:  op.kind = K_LTU;
            3'b111:  op.kind = K_GEU;
            default: legal = 1'b0;
         endcase
      end else if (fp_form) begin
         op.is_fp = 1'b1;
         legal    = fp_en;
         unique case (f3)
            3'b000:  op.kind = K_FLE;
            3'b001:  op.kind = K_FLT;
            3'b010:  op.kind = K_EQ;
            3'b011:  op.kind = K_NE;
            default: legal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/vcmp_fp_cmp.sv
module vcmp_fp_cmp (
   input  logic [31:0] a,
   input  logic [31:0] b,
   output logic        eq,
   output logic        lt,
   output logic        unord
);
   logic nan_a, nan_b, zeros, same_sign_lt;

   assign nan_a = (&a[30:23]) && (|a[22:0]);
   assign nan_b = (&b[30:23]) && (|b[22:0]);
   assign unord = nan_a || nan_b;
   assign zeros = ~(|a[30:0]) && ~(|b[30:0]);
   assign eq    = !unord && ((a == b) || zeros);
   assign same_sign_lt = a[31] ? (a[30:0] > b[30:0]) : (a[30:0] < b[30:0]);
   assign lt    = !unord && !eq && ((a[31] != b[31]) ? a[31] : same_sign_lt);
endmodule

// File: rtl/vcmp_elem.sv
module vcmp_elem
   import vcmp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  cmp_kind_e        kind,
   input  logic             is_fp,
   input  logic [XLEN-1:0]  ia,
   input  logic [XLEN-1:0]  ib,
   input  logic             feq,
   input  logic             flt,
   output logic             hit
);
   logic int_hit, fp_hit;

   always_comb begin
      unique case (kind)
         K_EQ:    int_hit = (ia == ib);
         K_NE:    int_hit = (ia != ib);
         K_LT:    int_hit = ($signed(ia) < $signed(ib));
         K_GE:    int_hit = ($signed(ia) >= $signed(ib));
         K_LTU:   int_hit = (ia < ib);
         K_GEU:   int_hit = (ia >= ib);
         default: int_hit = 1'b0;
      endcase
      unique case (kind)
         K_FLE:   fp_hit = feq || flt;
         K_FLT:   fp_hit = flt;
         K_EQ:    fp_hit = feq;
         K_NE:    fp_hit = !feq;
         default: fp_hit = 1'b0;
      endcase
   end

   assign hit = is_fp ? fp_hit : int_hit;
endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
   import vcmp_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int PRED_W = 16,
   parameter int VL_W   = 8,
   parameter bit FP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       instr,
   input  logic              int_pred_en,
   input  logic              fp_pred_en,
   input  logic [VL_W-1:0]   vl_a,
   input  logic [VL_W-1:0]   vl_b,
   output logic [4:0]        rd_addr_a,
   output logic [4:0]        rd_addr_b,
   input  logic [XLEN-1:0]   int_a,
   input  logic [XLEN-1:0]   int_b,
   input  logic [31:0]       fp_a,
   input  logic [31:0]       fp_b,
   output logic              pw_en,
   output logic              pw_fp,
   output logic [4:0]        pw_idx,
   output logic [PRED_W-1:0] pw_mask,
   output logic              done,
   output logic              illegal
);
   localparam int IDX_W = $clog2(PRED_W);

   if (PRED_W < 2 || PRED_W > 32) begin : g_bad_pred_w
      $error("PRED_W must lie in 2..32");
   end
   if (VL_W < 1 || VL_W > 16) begin : g_bad_vl_w
      $error("VL_W must lie in 1..16");
   end
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("XLEN must be 32 or 64");
   end

   seq_state_e        st;
   cmp_op_t           dec_op, op_q;
   logic              dec_legal;
   logic              vec_a, vec_b;
   logic [IDX_W-1:0]  cnt, last;
   logic [PRED_W-1:0] mask_q;
   logic [IDX_W-1:0]  last_nx;
   logic              feq, flt, funord, hit;

   vcmp_decode #(.FP_EN(FP_EN)) u_dec (
      .instr (instr),
      .int_en(int_pred_en),
      .fp_en (fp_pred_en),
      .op    (dec_op),
      .legal (dec_legal)
   );

   always_comb begin
      int unsigned m;
      m = (int'(vl_a) > int'(vl_b)) ? int'(vl_a) : int'(vl_b);
      if (m < 1) m = 1;
      if (m > PRED_W) m = PRED_W;
      last_nx = IDX_W'(m - 1);
   end

   assign rd_addr_a = op_q.src_a + (vec_a ? 5'(cnt) : 5'd0);
   assign rd_addr_b = op_q.src_b + (vec_b ? 5'(cnt) : 5'd0);

   if (FP_EN) begin : g_fp
      vcmp_fp_cmp u_fp (
         .a    (fp_a),
         .b    (fp_b),
         .eq   (feq),
         .lt   (flt),
         .unord(funord)
      );
   end else begin : g_no_fp
      assign feq    = 1'b0;
      assign flt    = 1'b0;
      assign funord = 1'b0;
   end

   vcmp_elem #(.XLEN(XLEN)) u_elem (
      .kind (op_q.kind),
      .is_fp(op_q.is_fp),
      .ia   (int_a),
      .ib   (int_b),
      .feq  (feq),
      .flt  (flt),
      .hit  (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= '0;
         vec_a  <= 1'b0;
         vec_b  <= 1'b0;
         cnt    <= '0;
         last   <= '0;
         mask_q <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               if (dec_legal) begin
                  op_q   <= dec_op;
                  vec_a  <= (int'(vl_a) > 1);
                  vec_b  <= (int'(vl_b) > 1);
                  cnt    <= '0;
                  last   <= last_nx;
                  mask_q <= '0;
                  st     <= S_RUN;
               end else begin
                  st <= S_ERR;
               end
            end
            S_RUN: begin
               mask_q[cnt] <= hit;
               if (cnt == last) st <= S_WRITE;
               else             cnt <= cnt + 1'b1;
            end
            S_WRITE: st <= S_FIN;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign pw_en   = (st == S_WRITE);
   assign done    = (st == S_FIN);
   assign illegal = (st == S_ERR);
   assign pw_fp   = op_q.is_fp;
   assign pw_idx  = op_q.dst;
   assign pw_mask = mask_q;
endmodule

// File: rtl/vcmp_pred_chk.sv
module vcmp_pred_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic pw_en,
   input logic done,
   input logic illegal
);
   AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pw_en |=> done); // R7
   AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pw_en |=> !pw_en); // R7
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(pw_en)); // R7
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pw_en, done, illegal})); // R8
   AST_ILLEGAL_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(start)); // R8
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> !pw_en && !done); // R8
endmodule

bind vcmp_pred_unit vcmp_pred_chk i_vcmp_pred_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .pw_en  (pw_en),
   .done   (done),
   .illegal(illegal)
);

// File: tb/test_vcmp_pred_unit.sv
module test_vcmp_pred_unit;
   localparam int PW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic        ien = 1'b1, fen = 1'b1;
   logic [7:0]  vla = '0, vlb = '0;
   logic [4:0]  ra, rb;
   logic [31:0] ia, ib, fa, fb;
   logic        pw_en, pw_fp, done, illegal;
   logic [4:0]  pw_idx;
   logic [PW-1:0] pw_mask;

   logic [31:0] ireg [32];
   logic [31:0] freg [32];
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   assign ia = ireg[ra];
   assign ib = ireg[rb];
   assign fa = freg[ra];
   assign fb = freg[rb];

   vcmp_pred_unit i_vcmp_pred_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .int_pred_en(ien), .fp_pred_en(fen), .vl_a(vla), .vl_b(vlb),
      .rd_addr_a(ra), .rd_addr_b(rb), .int_a(ia), .int_b(ib), .fp_a(fa), .fp_b(fb),
      .pw_en(pw_en), .pw_fp(pw_fp), .pw_idx(pw_idx), .pw_mask(pw_mask),
      .done(done), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_int(input logic [2:0] f3, input logic [4:0] s1,
                                          input logic [4:0] s2, input logic [4:0] pd,
                                          input logic [6:0] junk);
      return {junk, s2, s1, f3, pd, 7'b1100011};
   endfunction

   function automatic logic [31:0] mk_fp(input logic [2:0] f3, input logic [1:0] fmt,
                                         input logic [4:0] s1, input logic [4:0] s2,
                                         input logic [4:0] pd);
      return {5'b10100, fmt, s2, s1, f3, pd, 7'b1010011};
   endfunction

   function automatic bit is_fp_op(input logic [31:0] w);
      return w[6:0] == 7'b1010011;
   endfunction

   function automatic bit exp_illegal(input logic [31:0] w, input bit ie, input bit fe);
      if (w[6:0] == 7'b1100011) return !ie || w[14:13] == 2'b01;
      if (w[6:0] == 7'b1010011 && w[31:27] == 5'b10100 && w[26:25] != 2'b10)
         return !fe || w[14];
      return 1'b1;
   endfunction

   function automatic int exp_len(input int a, input int b);
      int m = (a > b) ? a : b;
      if (m < 1) m = 1;
      if (m > PW) m = PW;
      return m;
   endfunction

   function automatic longint fkey(input logic [31:0] v);
      longint mag = longint'(v[30:0]);
      return v[31] ? -mag : mag;
   endfunction

   function automatic bit fnan(input logic [31:0] v);
      return v[30:23] == 8'hFF && v[22:0] != 0;
   endfunction

   function automatic bit elem(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
      if (is_fp_op(w)) begin
         bit un = fnan(a) || fnan(b);
         case (w[14:12])
            3'b000:  return !un && fkey(a) <= fkey(b);
            3'b001:  return !un && fkey(a) <  fkey(b);
            3'b010:  return !un && fkey(a) == fkey(b);
            default: return un || fkey(a) != fkey(b);
         endcase
      end
      case (w[14:12])
         3'b000:  return a == b;
         3'b001:  return a != b;
         3'b100:  return $signed(a) <  $signed(b);
         3'b101:  return $signed(a) >= $signed(b);
         3'b110:  return a < b;
         default: return a >= b;
      endcase
   endfunction

   function automatic logic [PW-1:0] exp_mask(input logic [31:0] w, input int a, input int b);
      logic [PW-1:0] m = '0;
      int n = exp_len(a, b);
      for (int i = 0; i < n; i++) begin
         logic [4:0] xa = w[19:15] + ((a > 1) ? 5'(i) : 5'd0);
         logic [4:0] xb = w[24:20] + ((b > 1) ? 5'(i) : 5'd0);
         m[i] = is_fp_op(w) ? elem(w, freg[xa], freg[xb]) : elem(w, ireg[xa], ireg[xb]);
      end
      return m;
   endfunction

   task automatic run(input string req, input logic [31:0] w, input int a, input int b,
                      input bit ie, input bit fe, input bit poke);
      logic [PW-1:0] em;
      bit ill;
      int k;
      em  = exp_mask(w, a, b);
      ill = exp_illegal(w, ie, fe);
      @(negedge clk);
      instr = w; vla = 8'(a); vlb = 8'(b); ien = ie; fen = fe; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (ill) begin
         chk(illegal == 1'b1, "R8", {req, " illegal"}, illegal, 1);
         chk(pw_en == 1'b0, "R8", {req, " no write"}, pw_en, 0);
         @(negedge clk);
         chk(!done && !pw_en, "R8", {req, " no done"}, {done, pw_en}, 0);
         return;
      end
      k = 1;
      while (!pw_en && k < 40) begin
         if (poke && k == 1) begin
            instr = mk_int(3'b001, 5'd3, 5'd4, 5'd9, 7'h0); vla = 8'd1; vlb = 8'd1; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      chk(k == exp_len(a, b) + 1, "R7", {req, " write cycle"}, k, exp_len(a, b) + 1);
      chk(pw_mask == em, req, {req, " mask"}, pw_mask, em);
      chk(pw_idx == w[11:7] && pw_fp == is_fp_op(w), "R4", {req, " target"},
          {pw_fp, pw_idx}, {is_fp_op(w), w[11:7]});
      @(negedge clk);
      chk(done && !pw_en, "R7", {req, " done pulse"}, {done, pw_en}, 2'b10);
      @(negedge clk);
      chk(!done, "R7", {req, " done single"}, done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) begin
         ireg[i] = $urandom;
         freg[i] = $urandom;
      end
      ireg[8] = 32'hFFFF_FFFF; ireg[9] = 32'd1; ireg[10] = 32'd1;
      freg[0] = 32'h0000_0000; freg[1] = 32'h8000_0000; freg[2] = 32'h7FC0_0000;
      freg[3] = 32'h3F80_0000; freg[4] = 32'hBF80_0000; freg[5] = 32'hFF80_0000;
      freg[6] = 32'h7F80_0000; freg[7] = 32'h3F80_0000;
      repeat (3) @(negedge clk);
      chk(!pw_en && !done && !illegal, "R1", "reset quiet", {pw_en, done, illegal}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pw_en && !done && !illegal, "R1", "after reset", {pw_en, done, illegal}, 0);

      run("R2", mk_int(3'b110, 5'd8, 5'd9, 5'd2, 7'h00), 1, 1, 1, 1, 0);
      run("R2", mk_int(3'b100, 5'd8, 5'd9, 5'd3, 7'h7F), 1, 1, 1, 1, 0);
      run("R2", mk_int(3'b111, 5'd8, 5'd9, 5'd3, 7'h55), 1, 1, 1, 1, 0);
      run("R2", mk_int(3'b000, 5'd9, 5'd10, 5'd1, 7'h2A), 1, 1, 1, 1, 0);
      run("R3", mk_fp(3'b010, 2'b00, 5'd0, 5'd1, 5'd4), 1, 1, 1, 1, 0);
      run("R3", mk_fp(3'b011, 2'b01, 5'd2, 5'd2, 5'd5), 1, 1, 1, 1, 0);
      run("R3", mk_fp(3'b000, 2'b11, 5'd2, 5'd3, 5'd6), 1, 1, 1, 1, 0);
      run("R3", mk_fp(3'b001, 2'b00, 5'd5, 5'd0, 5'd6), 8, 1, 1, 1, 0);
      run("R5", mk_int(3'b001, 5'd30, 5'd8, 5'd7, 7'h00), 6, 0, 1, 1, 0);
      run("R5", mk_fp(3'b000, 2'b00, 5'd1, 5'd0, 5'd7), 0, 7, 1, 1, 0);
      run("R6", mk_int(3'b110, 5'd0, 5'd16, 5'd8, 7'h00), 20, 3, 1, 1, 0);
      run("R6", mk_int(3'b111, 5'd4, 5'd12, 5'd9, 7'h00), 3, 2, 1, 1, 0);
      run("R8", mk_int(3'b000, 5'd1, 5'd2, 5'd3, 7'h00), 4, 4, 0, 1, 0);
      run("R8", mk_fp(3'b010, 2'b00, 5'd1, 5'd2, 5'd3), 4, 4, 1, 0, 0);
      run("R8", mk_fp(3'b010, 2'b10, 5'd1, 5'd2, 5'd3), 4, 4, 1, 1, 0);
      run("R8", mk_int(3'b011, 5'd1, 5'd2, 5'd3, 7'h00), 4, 4, 1, 1, 0);
      run("R8", {25'h0, 7'b0110011}, 4, 4, 1, 1, 0);
      run("R9", mk_int(3'b100, 5'd10, 5'd20, 5'd11, 7'h00), 5, 5, 1, 1, 1);

      for (int t = 0; t < 150; t++) begin
         logic [31:0] w;
         logic [2:0] f3;
         if ($urandom_range(1, 0) == 1) begin
            f3 = 3'($urandom_range(3, 0));
            w = mk_fp(f3, 2'($urandom_range(1, 0)), 5'($urandom), 5'($urandom), 5'($urandom));
         end else begin
            f3 = 3'($urandom);
            if (f3[2:1] == 2'b01) f3[2] = 1'b1;
            w = mk_int(f3, 5'($urandom), 5'($urandom), 5'($urandom), 7'($urandom));
         end
         run(is_fp_op(w) ? "R3" : "R2", w, $urandom_range(20, 0), $urandom_range(20, 0),
             1, 1, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule